// File: doc/BRIEF.md
# Overload Hiccup Retry Controller

This block decides whether a supply output may drive its load while an overload comparator reports excess current. In the hiccup mode an overload cuts the output for a long rest interval. The output then comes back for a short probe window. At the end of that window the block looks at the overload once more. If the overload is still there, the rest and probe pair repeats. If it has cleared, the output stays on. In the static mode the output is left on during overload, because the current limit is applied elsewhere, and only a status flag records the event.

The overload input is already synchronized to the clock. It must be high for a number of consecutive clocks before it counts as a detection. A sticky status flag is offered for a register read. Interval lengths are given in milliseconds, with a parameter that gives the number of clocks per millisecond.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_en_o` and `ovl_stat_o` are 0. With `en_i` high, `out_en_o` rises one clock after reset is released.
- R2: An overload counts as detected only after `ovl_i` has been sampled high on DEB_LEN consecutive clock edges. Any shorter high run changes neither output.
- R3: When `static_lim_i` is 0 and the output is running, a detection drops `out_en_o` at the next clock edge.
- R4: After a trip, `out_en_o` stays low for exactly OFF_MS*CLKS_PER_MS clocks. `ovl_i` is ignored for that whole interval and cannot set the status flag.
- R5: After the rest interval, `out_en_o` is high for exactly ON_MS*CLKS_PER_MS clocks. The overload only changes the state at the last clock of this window: a detection present then starts a new rest interval.
- R6: If no detection is present at the last clock of the probe window, the block returns to normal running and `out_en_o` stays high.
- R7: When `static_lim_i` is 1, a detection leaves `out_en_o` high and sets `ovl_stat_o`.
- R8: When `en_i` is low, `out_en_o` is low in the same cycle, whatever the retry state. Any retry in progress is abandoned. When `en_i` returns high, the output turns on one clock later.
- R9: `ovl_stat_o` sets on any detection while the output is on. It stays set until a cycle with `stat_rd_i` high and `ovl_i` low. A read made while `ovl_i` is high leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global output enable |
| static_lim_i | input | 1 | 1 selects static limiting, 0 selects hiccup retry |
| ovl_i | input | 1 | Synchronized overload comparator flag |
| stat_rd_i | input | 1 | One-cycle strobe marking a read of the status flag |
| out_en_o | output | 1 | Output enable for the supply |
| ovl_stat_o | output | 1 | Sticky overload status |

## Verification
The bench measures the rest interval and the probe window in clocks. An off-by-one in the millisecond prescaler or the interval counter shows up as a window one clock or one millisecond too long or too short. It sends overload runs one clock shorter than the debounce length, which a design that counts the wrong edge would trip on. It keeps the overload high through a whole probe window and drops it only during a rest, which separates re-judging at the end of the window from tripping early or never retrying. It also reads the status flag while the fault is still present, and drops the enable in the middle of a retry, where a weak design either loses the flag or leaves the output driven.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REST  = 2'd2,
    ST_PROBE = 2'd3
  } hic_state_t;
endpackage

// File: rtl/hiccup_debounce.sv
module hiccup_debounce #(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ovl_i,
  output logic det_o
);
  localparam int W = $clog2(DEB_LEN + 1);
  localparam logic [W-1:0] FULL = W'(DEB_LEN);

  logic [W-1:0] run_q, run_d;

  always_comb begin
    if (clr_i || !ovl_i) run_d = '0;
    else if (run_q == FULL) run_d = run_q;
    else run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign det_o = (run_q == FULL);
endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int CLKS_PER_MS = 125000,
  parameter int OFF_MS      = 900,
  parameter int ON_MS       = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic long_i,
  output logic done_o
);
  localparam int MAXMS = (OFF_MS > ON_MS) ? OFF_MS : ON_MS;
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MW = (MAXMS > 1) ? $clog2(MAXMS) : 1;
  localparam logic [PW-1:0] P_LAST   = PW'(CLKS_PER_MS - 1);
  localparam logic [MW-1:0] M_LAST_L = MW'(OFF_MS - 1);
  localparam logic [MW-1:0] M_LAST_S = MW'(ON_MS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          run_q, run_d;
  logic          pre_wrap;
  logic [MW-1:0] ms_last;

  assign pre_wrap = (pre_q == P_LAST);
  assign ms_last  = long_i ? M_LAST_L : M_LAST_S;
  assign done_o   = run_q && pre_wrap && (ms_q == ms_last);

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    run_d = run_q;
    if (clr_i) begin
      run_d = 1'b0;
    end else if (start_i) begin
      run_d = 1'b1;
      pre_d = '0;
      ms_d  = '0;
    end else if (run_q) begin
      if (done_o) run_d = 1'b0;
      if (pre_wrap) begin
        pre_d = '0;
        ms_d  = ms_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/hiccup_status.sv
module hiccup_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic fault_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)                 flag_d = 1'b1;
    else if (rd_i && !fault_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int CLKS_PER_MS = 125000,
  parameter int OFF_MS      = 900,
  parameter int ON_MS       = 20,
  parameter int DEB_LEN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic static_lim_i,
  input  logic ovl_i,
  input  logic stat_rd_i,
  output logic out_en_o,
  output logic ovl_stat_o
);
  hic_state_t st_q, st_d;
  logic ovl_det;
  logic tmr_done;
  logic tmr_start;
  logic deb_clr;
  logic live;

  assign live    = (st_q == ST_RUN) || (st_q == ST_PROBE);
  assign deb_clr = !en_i || (st_q == ST_IDLE) || (st_q == ST_REST);

  hiccup_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk(clk), .rst_n(rst_n), .clr_i(deb_clr), .ovl_i(ovl_i), .det_o(ovl_det)
  );

  hiccup_timer #(.CLKS_PER_MS(CLKS_PER_MS), .OFF_MS(OFF_MS), .ON_MS(ON_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(!en_i), .start_i(tmr_start),
    .long_i(st_q == ST_REST), .done_o(tmr_done)
  );

  hiccup_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(en_i && live && ovl_det),
    .rd_i(stat_rd_i), .fault_i(ovl_i), .flag_o(ovl_stat_o)
  );

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_RUN;
        ST_RUN: begin
          if (ovl_det && !static_lim_i) begin
            st_d      = ST_REST;
            tmr_start = 1'b1;
          end
        end
        ST_REST: begin
          if (tmr_done) begin
            st_d      = ST_PROBE;
            tmr_start = 1'b1;
          end
        end
        ST_PROBE: begin
          if (tmr_done) begin
            if (ovl_det) begin
              st_d      = ST_REST;
              tmr_start = 1'b1;
            end else begin
              st_d = ST_RUN;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign out_en_o = en_i && live;
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk
  import hiccup_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       static_lim_i,
  input logic       stat_rd_i,
  input logic       out_en_o,
  input logic       ovl_stat_o,
  input hic_state_t st,
  input logic       det,
  input logic       tmr_done
);
  a_r8_disable_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st == ST_IDLE));

  a_r3_trip_to_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st == ST_RUN && det && !static_lim_i) |=> (st == ST_REST || !en_i));

  a_r7_static_no_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st == ST_RUN && static_lim_i) |=> (st != ST_REST));

  a_r4_rest_no_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REST && !ovl_stat_o) |=> !ovl_stat_o);

  a_r4_rest_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REST) |-> !out_en_o);

  a_r5_rest_leads_to_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REST && en_i && tmr_done) |=> (st == ST_PROBE || !en_i));

  a_r6_clean_probe_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROBE && en_i && tmr_done && !det) |=> (st == ST_RUN || !en_i));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_stat_o && !stat_rd_i) |=> ovl_stat_o);
endmodule

bind hiccup_guard hiccup_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .static_lim_i(static_lim_i),
  .stat_rd_i(stat_rd_i), .out_en_o(out_en_o), .ovl_stat_o(ovl_stat_o),
  .st(st_q), .det(ovl_det), .tmr_done(tmr_done)
);

// File: tb/hiccup_guard_test.sv
module hiccup_guard_test;
  localparam int CPM  = 4;
  localparam int OFFM = 30;
  localparam int ONM  = 5;
  localparam int DEB  = 3;
  localparam int OFFC = OFFM * CPM;
  localparam int ONC  = ONM * CPM;

  logic clk, rst_n, en_i, static_lim_i, ovl_i, stat_rd_i;
  logic out_en_o, ovl_stat_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  hiccup_guard #(.CLKS_PER_MS(CPM), .OFF_MS(OFFM), .ON_MS(ONM), .DEB_LEN(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .static_lim_i(static_lim_i),
    .ovl_i(ovl_i), .stat_rd_i(stat_rd_i), .out_en_o(out_en_o), .ovl_stat_o(ovl_stat_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: 0 idle, 1 running, 2 resting, 3 probing
  int m_st, m_run, m_left;
  logic m_flag;

  function automatic logic m_det(int run);
    return run == DEB;
  endfunction

  function automatic logic m_out(int st, logic en);
    return en && (st == 1 || st == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_run <= 0; m_left <= 0; m_flag <= 1'b0;
    end else begin
      if (!en_i || m_st == 0 || m_st == 2 || !ovl_i) m_run <= 0;
      else m_run <= (m_run == DEB) ? DEB : m_run + 1;
      if (en_i && (m_st == 1 || m_st == 3) && m_det(m_run)) m_flag <= 1'b1;
      else if (stat_rd_i && !ovl_i) m_flag <= 1'b0;
      if (!en_i) m_st <= 0;
      else begin
        case (m_st)
          0: m_st <= 1;
          1: if (m_det(m_run) && !static_lim_i) begin m_st <= 2; m_left <= OFFC - 1; end
          2: if (m_left == 0) begin m_st <= 3; m_left <= ONC - 1; end
             else m_left <= m_left - 1;
          default: if (m_left == 0) begin
                     if (m_det(m_run)) begin m_st <= 2; m_left <= OFFC - 1; end
                     else m_st <= 1;
                   end else m_left <= m_left - 1;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model, then move on to the next falling edge.
  task automatic cyc();
    #1;
    check(out_en_o === m_out(m_st, en_i), cur_req, "out_en_o", int'(out_en_o), int'(m_out(m_st, en_i)));
    check(ovl_stat_o === m_flag, cur_req, "ovl_stat_o", int'(ovl_stat_o), int'(m_flag));
    @(negedge clk);
  endtask

  task automatic cycs(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic read_flag();
    stat_rd_i = 1'b1; cyc(); stat_rd_i = 1'b0;
  endtask

  int n;

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; en_i = 1'b1; static_lim_i = 1'b0; ovl_i = 1'b0; stat_rd_i = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    cycs(3);
    check(out_en_o === 1'b0, "R1", "out_en in reset", int'(out_en_o), 0);
    check(ovl_stat_o === 1'b0, "R1", "flag in reset", int'(ovl_stat_o), 0);
    rst_n = 1'b1;
    #1;
    check(out_en_o === 1'b0, "R1", "out_en first cycle", int'(out_en_o), 0);
    @(negedge clk);
    check(out_en_o === 1'b1, "R1", "out_en after release", int'(out_en_o), 1);
    cycs(5);

    // R2: glitch one clock short of the debounce length
    cur_req = "R2";
    ovl_i = 1'b1; cycs(DEB - 1); ovl_i = 1'b0; cycs(4);
    check(out_en_o === 1'b1, "R2", "out_en after short glitch", int'(out_en_o), 1);
    check(ovl_stat_o === 1'b0, "R2", "flag after short glitch", int'(ovl_stat_o), 0);

    // R3 / R4: persistent overload, measure the rest interval
    cur_req = "R3";
    ovl_i = 1'b1;
    n = 0;
    while (out_en_o && n < 20) begin cyc(); n++; end
    check(n == DEB + 1, "R3", "clocks to trip", n, DEB + 1);
    cur_req = "R4";
    n = 0;
    while (!out_en_o && n < 10 * OFFC) begin cyc(); n++; end
    check(n == OFFC, "R4", "rest length", n, OFFC);

    // R5: probe window with fault held, expect another rest
    cur_req = "R5";
    n = 0;
    while (out_en_o && n < 10 * ONC) begin cyc(); n++; end
    check(n == ONC, "R5", "probe length", n, ONC);
    check(out_en_o === 1'b0, "R5", "rest again", int'(out_en_o), 0);

    // R9: read while fault present keeps the flag
    cur_req = "R9";
    read_flag();
    check(ovl_stat_o === 1'b1, "R9", "flag kept on read with fault", int'(ovl_stat_o), 1);

    // R6: fault clears during rest, probe ends clean
    cur_req = "R6";
    cycs(10); ovl_i = 1'b0;
    while (!out_en_o) cyc();
    cycs(ONC + 30);
    check(out_en_o === 1'b1, "R6", "stays on after clean probe", int'(out_en_o), 1);
    read_flag();
    check(ovl_stat_o === 1'b0, "R9", "flag cleared on read", int'(ovl_stat_o), 0);

    // R5: brief fault in middle of probe, absent at its end
    cur_req = "R5";
    ovl_i = 1'b1;
    while (out_en_o) cyc();
    ovl_i = 1'b0;
    while (!out_en_o) cyc();
    cycs(2); ovl_i = 1'b1; cycs(DEB + 1); ovl_i = 1'b0;
    cycs(ONC + 10);
    check(out_en_o === 1'b1, "R5", "mid-probe fault not judged", int'(out_en_o), 1);
    check(ovl_stat_o === 1'b1, "R9", "flag set by mid-probe fault", int'(ovl_stat_o), 1);
    read_flag();

    // R7: static limiting
    cur_req = "R7";
    static_lim_i = 1'b1; ovl_i = 1'b1; cycs(40);
    check(out_en_o === 1'b1, "R7", "out_en under static limit", int'(out_en_o), 1);
    check(ovl_stat_o === 1'b1, "R7", "flag under static limit", int'(ovl_stat_o), 1);
    ovl_i = 1'b0; read_flag(); static_lim_i = 1'b0;

    // R8: disable in run and mid-rest
    cur_req = "R8";
    en_i = 1'b0; #1;
    check(out_en_o === 1'b0, "R8", "out_en same cycle", int'(out_en_o), 0);
    @(negedge clk); cycs(3);
    en_i = 1'b1; cyc();
    check(out_en_o === 1'b1, "R8", "out_en one clock after enable", int'(out_en_o), 1);
    ovl_i = 1'b1;
    while (out_en_o) cyc();
    cycs(20); ovl_i = 1'b0; en_i = 1'b0; cycs(2); en_i = 1'b1; cyc();
    check(out_en_o === 1'b1, "R8", "retry abandoned on re-enable", int'(out_en_o), 1);

    // Random phase against the model
    cur_req = "random";
    for (int k = 0; k < 30000; k++) begin
      if ($urandom_range(0, 29) == 0) ovl_i = ~ovl_i;
      if ($urandom_range(0, 7) == 0) ovl_i = ($urandom_range(0, 3) == 0);
      en_i = ($urandom_range(0, 999) != 0);
      if ($urandom_range(0, 1999) == 0) static_lim_i = ~static_lim_i;
      stat_rd_i = ($urandom_range(0, 49) == 0);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule